// File: doc/BRIEF.md
# Trigger Accept Busy Handler

This block stands between a central level-1 trigger source, a slow front-end readout and a downstream readout system that expects exactly one answer for every trigger it issued. Readout of a full event takes far longer than the spacing between triggers. For that reason only one trigger at a time is passed on to the front-end. Every trigger that arrives during that readout is remembered by its ID and answered later with an empty response.

When idle, an incoming trigger is forwarded in the same cycle and the block turns busy. While busy, further trigger IDs go into an ordered pending store. When event building reports completion together with the event length, the block presents one full response for the forwarded trigger. It then presents one empty response per stored ID, oldest first. Responses leave through a valid/ready stream. The block returns to idle only once the last response has been taken. If the pending store is full, the IDs that do not fit are dropped and a sticky error flag is raised.

Top module: `trig_busy_handler`

## Requirements
- R1: After reset, busy, respValid, fwdValid and overflowErr are all 0.
- R2: A trigger (trigValid=1) while idle drives fwdValid=1 with fwdId equal to trigId in that same cycle, and busy reads 1 from the next cycle on.
- R3: A trigger while busy is never forwarded: fwdValid stays 0 and the ID is appended to the pending store.
- R4: One cycle after doneValid is seen while waiting, respValid=1 with respFull=1, respId equal to the forwarded trigger's ID and respLen equal to the doneLen sampled with doneValid.
- R5: After the full response is taken, one response is presented per stored ID, in arrival order, each with respFull=0 and respLen=0.
- R6: A trigger in the same cycle as doneValid counts as arriving while busy: it is not forwarded and it is answered with an empty response.
- R7: busy stays 1 until the cycle in which the last pending response is accepted (respValid=1 and respReady=1), and it reads 0 from the following cycle on.
- R8: The pending store holds DEPTH IDs. A trigger that finds it full is dropped and sets overflowErr, which stays 1 until reset.
- R9: While respValid=1 and respReady=0, respValid, respId, respFull and respLen hold their values into the next cycle.
- R10: doneValid while idle has no effect: no response appears and busy stays 0.
- R11: Triggers that arrive while responses are being sent are also queued, and they are answered after the IDs stored before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trigValid | input | 1 | Trigger accept strobe |
| trigId | input | ID_W | ID of the incoming trigger |
| fwdValid | output | 1 | Trigger forwarded to the front-end |
| fwdId | output | ID_W | ID of the forwarded trigger |
| doneValid | input | 1 | Event building finished |
| doneLen | input | LEN_W | Length of the built event |
| respValid | output | 1 | Response available |
| respReady | input | 1 | Downstream accepts the response |
| respId | output | ID_W | Trigger ID the response answers |
| respFull | output | 1 | 1 for the built event, 0 for an empty response |
| respLen | output | LEN_W | Event length, 0 for empty responses |
| busy | output | 1 | A forwarded trigger is still being answered |
| overflowErr | output | 1 | Sticky: a pending ID was dropped |

## Verification
The hardest conditions to reach are the ones where a trigger meets a state change in the same cycle. One case is a trigger arriving with the completion strobe. Another is a trigger arriving while the response stream is stalled or draining. A third is a trigger that finds the pending store exactly full. The bench uses a four-entry store and sweeps the number of queued triggers from zero to two past the depth. For each count it runs every combination of the same-cycle trigger, a late trigger during the response phase, and an alternating ready stall, and it predicts the full response sequence and the error flag from those counts.

// File: rtl/trig_busy_pkg.sv
package trig_busy_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadActive;  // capture ID of forwarded trigger
    logic push;        // trigger arrived while busy
    logic pop;         // empty response accepted
    logic loadLen;     // capture event length
    logic selFull;     // present full response
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_FULL  = 2'd2,
    ST_EMPTY = 2'd3
  } state_t;

endpackage

// File: rtl/trig_busy_datapath.sv
module trig_busy_datapath
  import trig_busy_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int LEN_W = 16,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_t            ctl,
  input  logic [ID_W-1:0]  trigId,
  input  logic [LEN_W-1:0] doneLen,
  output logic [ID_W-1:0]  respId,
  output logic             respFull,
  output logic [LEN_W-1:0] respLen,
  output logic             fifoEmpty,
  output logic             fifoLast,
  output logic             overflowErr
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);

  logic [ID_W-1:0]  activeId;
  logic [LEN_W-1:0] lenReg;
  logic [ID_W-1:0]  slotMem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             pushOk;
  logic             errReg;

  assign pushOk    = ctl.push && (count < CNT_MAX);
  assign fifoEmpty = (count == '0);
  assign fifoLast  = (count == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeId <= '0;
      lenReg   <= '0;
    end else begin
      if (ctl.loadActive) activeId <= trigId;
      if (ctl.loadLen)    lenReg   <= doneLen;
    end
  end

  // One storage row per slot
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotMem[s] <= '0;
      end else if (pushOk && (wrPtr == PTR_W'(s))) begin
        slotMem[s] <= trigId;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      count  <= '0;
      errReg <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == PTR_MAX) ? '0 : wrPtr + PTR_W'(1);
      if (ctl.pop) rdPtr <= (rdPtr == PTR_MAX) ? '0 : rdPtr + PTR_W'(1);
      count <= count + CNT_W'(pushOk) - CNT_W'(ctl.pop);
      if (ctl.push && !pushOk) errReg <= 1'b1;
    end
  end

  assign overflowErr = errReg;

  always_comb begin
    if (ctl.selFull) begin
      respId   = activeId;
      respFull = 1'b1;
      respLen  = lenReg;
    end else begin
      respId   = slotMem[rdPtr];
      respFull = 1'b0;
      respLen  = '0;
    end
  end

  // R5: a pop never hits an empty store
  a_r5_pop_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    ctl.pop |-> !fifoEmpty);

  // R8: occupancy never exceeds the depth
  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_MAX);

  // R8: error flag is sticky
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    errReg |=> errReg);

endmodule

// File: rtl/trig_busy_control.sv
module trig_busy_control
  import trig_busy_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  trigValid,
  input  logic  doneValid,
  input  logic  respReady,
  input  logic  fifoEmpty,
  input  logic  fifoLast,
  output ctrl_t ctl,
  output logic  fwdValid,
  output logic  respValid,
  output logic  busy
);

  state_t state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl       = '0;
    fwdValid  = 1'b0;
    respValid = 1'b0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (trigValid) begin
          fwdValid       = 1'b1;
          ctl.loadActive = 1'b1;
          nextState      = ST_WAIT;
        end
      end
      ST_WAIT: begin
        ctl.push = trigValid;
        if (doneValid) begin
          ctl.loadLen = 1'b1;
          nextState   = ST_FULL;
        end
      end
      ST_FULL: begin
        ctl.push    = trigValid;
        ctl.selFull = 1'b1;
        respValid   = 1'b1;
        if (respReady) nextState = (fifoEmpty && !trigValid) ? ST_IDLE : ST_EMPTY;
      end
      ST_EMPTY: begin
        ctl.push  = trigValid;
        respValid = 1'b1;
        if (respReady) begin
          ctl.pop = 1'b1;
          if (fifoLast && !trigValid) nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);

  // R2: a forwarded trigger makes the block busy
  a_r2_fwd_then_busy: assert property (@(posedge clk) disable iff (!rstN)
    fwdValid |=> busy);

  // R4: the first response after completion is the full one
  a_r4_first_full: assert property (@(posedge clk) disable iff (!rstN)
    $rose(respValid) |-> ctl.selFull);

  // R7: busy only drops after a handshake
  a_r7_release_on_accept: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(respValid && respReady));

  // R9: a stalled response is held
  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respReady) |=> respValid);

endmodule

// File: rtl/trig_busy_handler.sv
module trig_busy_handler
  import trig_busy_pkg::*;
#(
  parameter int ID_W  = 8,
  parameter int LEN_W = 16,
  parameter int DEPTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigValid,
  input  logic [ID_W-1:0]  trigId,
  output logic             fwdValid,
  output logic [ID_W-1:0]  fwdId,
  input  logic             doneValid,
  input  logic [LEN_W-1:0] doneLen,
  output logic             respValid,
  input  logic             respReady,
  output logic [ID_W-1:0]  respId,
  output logic             respFull,
  output logic [LEN_W-1:0] respLen,
  output logic             busy,
  output logic             overflowErr
);

  ctrl_t ctl;
  logic  fifoEmpty, fifoLast;

  trig_busy_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .trigValid (trigValid),
    .doneValid (doneValid),
    .respReady (respReady),
    .fifoEmpty (fifoEmpty),
    .fifoLast  (fifoLast),
    .ctl       (ctl),
    .fwdValid  (fwdValid),
    .respValid (respValid),
    .busy      (busy)
  );

  trig_busy_datapath #(
    .ID_W  (ID_W),
    .LEN_W (LEN_W),
    .DEPTH (DEPTH)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .trigId      (trigId),
    .doneLen     (doneLen),
    .respId      (respId),
    .respFull    (respFull),
    .respLen     (respLen),
    .fifoEmpty   (fifoEmpty),
    .fifoLast    (fifoLast),
    .overflowErr (overflowErr)
  );

  assign fwdId = trigId;

  // R3: nothing is forwarded while busy
  a_r3_no_fwd_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !fwdValid);

  // R9: stalled response content is stable
  a_r9_stable_payload: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respReady) |=> ($stable(respId) && $stable(respFull) && $stable(respLen)));

endmodule

// File: tb/trig_busy_handler_test.sv
module trig_busy_handler_test;

  localparam int PERIOD = 10;
  localparam int ID_W   = 8;
  localparam int LEN_W  = 16;
  localparam int DEPTH  = 4;

  logic             clk = 1'b0;
  logic             rstN;
  logic             trigValid;
  logic [ID_W-1:0]  trigId;
  logic             fwdValid;
  logic [ID_W-1:0]  fwdId;
  logic             doneValid;
  logic [LEN_W-1:0] doneLen;
  logic             respValid;
  logic             respReady;
  logic [ID_W-1:0]  respId;
  logic             respFull;
  logic [LEN_W-1:0] respLen;
  logic             busy;
  logic             overflowErr;

  int checks = 0;
  int fails  = 0;

  int expId   [16];
  int expFull [16];
  int expLen  [16];
  int expN;
  int nextId;
  bit errExp;

  always #(PERIOD/2) clk = ~clk;

  trig_busy_handler #(.ID_W(ID_W), .LEN_W(LEN_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rstN(rstN), .trigValid(trigValid), .trigId(trigId),
    .fwdValid(fwdValid), .fwdId(fwdId), .doneValid(doneValid), .doneLen(doneLen),
    .respValid(respValid), .respReady(respReady), .respId(respId),
    .respFull(respFull), .respLen(respLen), .busy(busy), .overflowErr(overflowErr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; trigValid = 0; doneValid = 0; respReady = 0; trigId = '0; doneLen = '0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk(!busy, "R1 busy", busy, 0);
    chk(!respValid, "R1 respValid", respValid, 0);
    chk(!fwdValid, "R1 fwdValid", fwdValid, 0);
    chk(!overflowErr, "R1 overflowErr", overflowErr, 0);
    errExp = 0;
  endtask

  task automatic queueExp(input int id);
    if (expN - 1 < DEPTH) begin
      expId[expN] = id; expFull[expN] = 0; expLen[expN] = 0; expN++;
    end else begin
      errExp = 1;
    end
  endtask

  // One event: n triggers while waiting; pat bit0 stall, bit1 trigger with done, bit2 late trigger
  task automatic runEvent(input int n, input int pat);
    int len;
    int idx;
    int cyc;
    bit prevStall;
    int pId, pFull, pLen;
    len = 16'h100 + n * 8 + pat;
    expN = 0; prevStall = 0; pId = 0; pFull = 0; pLen = 0;

    // R10: completion while idle does nothing
    @(negedge clk);
    doneValid = 1; doneLen = 16'hBEEF;
    @(negedge clk);
    doneValid = 0;
    #1;
    chk(!respValid, "R10 respValid", respValid, 0);
    chk(!busy, "R10 busy", busy, 0);

    // R2: forward while idle
    trigValid = 1; trigId = ID_W'(nextId);
    #1;
    chk(fwdValid, "R2 fwdValid", fwdValid, 1);
    chk(fwdId == ID_W'(nextId), "R2 fwdId", fwdId, nextId);
    expId[0] = nextId; expFull[0] = 1; expLen[0] = len; expN = 1;
    nextId = (nextId + 1) % 256;
    @(negedge clk);
    trigValid = 0;
    #1;
    chk(busy, "R2 busy", busy, 1);

    // R3: triggers while waiting
    for (int k = 0; k < n; k++) begin
      trigValid = 1; trigId = ID_W'(nextId);
      #1;
      chk(!fwdValid, "R3 fwdValid", fwdValid, 0);
      queueExp(nextId);
      nextId = (nextId + 1) % 256;
      @(negedge clk);
      trigValid = 0;
    end

    // R4 / R6: completion, optionally with a trigger
    doneValid = 1; doneLen = LEN_W'(len);
    if (pat[1]) begin
      trigValid = 1; trigId = ID_W'(nextId);
      #1;
      chk(!fwdValid, "R6 fwdValid", fwdValid, 0);
      queueExp(nextId);
      nextId = (nextId + 1) % 256;
    end
    @(negedge clk);
    doneValid = 0; trigValid = 0;
    #1;
    chk(respValid && respFull, "R4 full first", {respValid, respFull}, 3);

    // Drain responses
    idx = 0; cyc = 0;
    while (idx < expN && cyc < 200) begin
      if (cyc > 0) @(negedge clk);
      respReady = pat[0] ? cyc[0] : 1'b1;
      trigValid = 0;
      if (pat[2] && cyc == 0 && expN - 1 < DEPTH) begin
        trigValid = 1; trigId = ID_W'(nextId);
        queueExp(nextId); // R11
        nextId = (nextId + 1) % 256;
      end
      #1;
      chk(busy, "R7 busy held", busy, 1);
      if (prevStall) begin
        chk(respValid && respId == ID_W'(pId) && respFull == pFull[0] && respLen == LEN_W'(pLen),
            "R9 stall hold", respId, pId);
      end
      if (respValid && respReady) begin
        chk(respId == ID_W'(expId[idx]), expFull[idx] ? "R4 respId" : "R5 respId", respId, expId[idx]);
        chk(respFull == expFull[idx][0], "R5 respFull", respFull, expFull[idx]);
        chk(respLen == LEN_W'(expLen[idx]), expFull[idx] ? "R4 respLen" : "R5 respLen", respLen, expLen[idx]);
        idx++;
        prevStall = 0;
      end else begin
        prevStall = respValid;
        pId = respId; pFull = respFull; pLen = respLen;
      end
      cyc++;
    end
    @(negedge clk);
    respReady = 0; trigValid = 0;
    #1;
    chk(!busy, "R7 released", busy, 0);
    chk(!respValid, "R7 no extra response", respValid, 0);
    chk(overflowErr == errExp, "R8 overflowErr", overflowErr, errExp);
    if (errExp) doReset();
  endtask

  initial begin
    #(PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 0; trigValid = 0; trigId = '0; doneValid = 0; doneLen = '0; respReady = 0;
    nextId = 1; errExp = 0; expN = 0;
    doReset();
    for (int n = 0; n <= DEPTH + 2; n++) begin
      for (int pat = 0; pat < 8; pat++) begin
        runEvent(n, pat);
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule